// File: doc/BRIEF.md
# Serial command transmitter with launch delay

This block shifts a fixed-format command frame out to an external converter over a two-wire serial link: a slow serial clock and a data line. Everything runs on one fast system clock. The serial clock is made inside the block by a divide counter. It is a plain register output and never clocks any logic.

Each frame carries a leading one, the command byte with its most significant bit first, an odd parity bit and a trailing zero. The converter samples data some time after the serial clock falls, and it needs a minimum setup gap after that falling edge. So the block does not change data on the edge. It detects the falling edge in the system clock domain, runs a small enable-controlled counter, and drives the next bit only when that counter reaches its terminal value. At 50 MHz the default gap is 4 cycles, or 80 ns, which meets the 50 ns minimum with margin.

A caller raises `start_i` for one cycle with the command on `cmd_i`. It then waits for the `done_o` pulse, or for `busy_o` to fall.

Top module: `sercmd_tx`

## Requirements
- R1: The active-low asynchronous reset `rst_ni` drives `sclk_o`, `sdata_o`, `busy_o` and `done_o` to 0 at once, including in the middle of a frame. The internal divide counter, delay counter and bit index clear at the same time.
- R2: If `start_i` is high while `busy_o` is low, `busy_o` is high from the next cycle. The value on `cmd_i` is captured in that same cycle.
- R3: While busy, `sclk_o` starts low and toggles once every DIV_LAST+1 system cycles, with a default of 1302. Its first falling edge comes 2*(DIV_LAST+1) cycles after the start is accepted. Consecutive falling edges are exactly 2*(DIV_LAST+1) cycles apart.
- R4: Each new frame bit appears on `sdata_o` exactly DLY_LAST+2 system cycles after `sclk_o` falls, which is 4 cycles by default. Until then `sdata_o` holds its previous value. The delay counter never goes above DLY_LAST.
- R5: The frame holds 11 bits, launched after falling edges 1 to 11 of the frame in this order:
  - a 1;
  - `cmd_i[7]` down to `cmd_i[0]`;
  - the parity bit;
  - a 0.
- R6: The parity bit is odd parity over the command byte. It is 1 when the byte holds an even number of ones, and 0 otherwise.
- R7: The final 0 is held for one full serial clock period. At the launch point of the 12th falling edge, `busy_o` drops and `done_o` is high for exactly one cycle.
- R8: A `start_i` pulse while `busy_o` is high is ignored, along with any new value on `cmd_i`. The frame in progress continues unchanged and does not restart.
- R9: While idle, `sclk_o` and `sdata_o` stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock (50 MHz nominal) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to send one frame; acted on only when idle |
| cmd_i | input | CMD_W (8) | Command byte, captured when a start is accepted |
| sclk_o | output | 1 | Divided serial clock |
| sdata_o | output | 1 | Serial data, launched after the setup delay |
| busy_o | output | 1 | High from start acceptance to the end of the frame |
| done_o | output | 1 | One-cycle pulse when a frame completes |

## Verification
A fault in the divide counter shows on `sclk_o` within one half period, as a wrong fall-to-fall spacing. A fault in the delay counter or its enable moves the data change away from the fourth cycle after a fall, and that is visible on the very next bit. A fault in the bit index or the shift register sends a wrong bit, or ends the frame at the wrong edge. Either way, `busy_o` and `done_o` at the twelfth fall expose it within one frame.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;
  localparam logic START_VAL = 1'b1;
  localparam logic STOP_VAL  = 1'b0;
  localparam int unsigned OVERHEAD_BITS = 3;  // start, parity, stop

  function automatic int unsigned frame_len(input int unsigned cmd_w);
    return cmd_w + OVERHEAD_BITS;
  endfunction
endpackage

// File: rtl/sercmd_sclk_div.sv
module sercmd_sclk_div #(
  parameter int unsigned DIV_LAST = 1301
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sclk_o,
  output logic fall_o
);
  localparam int unsigned CW = $clog2(DIV_LAST + 1);

  logic [CW-1:0] cnt_q;
  logic          sclk_q, sclk_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      sclk_q   <= 1'b0;
      sclk_d_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q    <= '0;
      sclk_q   <= 1'b0;
      sclk_d_q <= 1'b0;
    end else begin
      sclk_d_q <= sclk_q;
      if (cnt_q == CW'(DIV_LAST)) begin
        cnt_q  <= '0;
        sclk_q <= ~sclk_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign sclk_o = sclk_q;
  // falling edge seen in the fast domain, one cycle after it happens
  assign fall_o = run_i & sclk_d_q & ~sclk_q;
endmodule

// File: rtl/sercmd_launch_delay.sv
module sercmd_launch_delay #(
  parameter int unsigned DLY_LAST = 2,
  parameter int unsigned CW       = $clog2(DLY_LAST + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  output logic [CW-1:0] cnt_o,
  output logic          ovf_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (!en_i)                      cnt_q <= '0;
    else if (cnt_q != CW'(DLY_LAST))     cnt_q <= cnt_q + 1'b1;  // saturate
  end

  assign cnt_o = cnt_q;
  assign ovf_o = en_i & (cnt_q == CW'(DLY_LAST));
endmodule

// File: rtl/sercmd_frame_seq.sv
module sercmd_frame_seq
  import sercmd_pkg::*;
#(
  parameter int unsigned CMD_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             fall_i,
  input  logic             ovf_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             sdata_o,
  output logic             dly_en_o
);
  localparam int unsigned FRAME_BITS = frame_len(CMD_W);
  localparam int unsigned IW         = $clog2(FRAME_BITS + 1);

  logic                  busy_q, done_q, sdata_q, en_q;
  logic [IW-1:0]         idx_q;
  logic [FRAME_BITS-1:0] shreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      sdata_q <= 1'b0;
      en_q    <= 1'b0;
      idx_q   <= '0;
      shreg_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        en_q <= 1'b0;
        if (start_i) begin
          busy_q  <= 1'b1;
          idx_q   <= '0;
          shreg_q <= {START_VAL, cmd_i, ~^cmd_i, STOP_VAL};
        end
      end else if (fall_i) begin
        en_q <= 1'b1;
      end else if (ovf_i) begin
        en_q <= 1'b0;
        if (idx_q == IW'(FRAME_BITS)) begin
          // stop bit has had a full period
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          sdata_q <= 1'b0;
          idx_q   <= '0;
        end else begin
          sdata_q <= shreg_q[FRAME_BITS-1];
          shreg_q <= {shreg_q[FRAME_BITS-2:0], 1'b0};
          idx_q   <= idx_q + 1'b1;
        end
      end
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign sdata_o  = sdata_q;
  assign dly_en_o = en_q;
endmodule

// File: rtl/sercmd_tx.sv
module sercmd_tx #(
  parameter int unsigned CMD_W    = 8,
  parameter int unsigned DIV_LAST = 1301,
  parameter int unsigned DLY_LAST = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CMD_W-1:0] cmd_i,
  output logic             sclk_o,
  output logic             sdata_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int unsigned DLY_CW = $clog2(DLY_LAST + 1);

  logic              fall, ovf, dly_en, busy;
  logic [DLY_CW-1:0] dly_cnt;

  sercmd_sclk_div #(.DIV_LAST(DIV_LAST)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .sclk_o (sclk_o),
    .fall_o (fall)
  );

  sercmd_launch_delay #(.DLY_LAST(DLY_LAST), .CW(DLY_CW)) u_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (dly_en),
    .cnt_o  (dly_cnt),
    .ovf_o  (ovf)
  );

  sercmd_frame_seq #(.CMD_W(CMD_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .cmd_i    (cmd_i),
    .fall_i   (fall),
    .ovf_i    (ovf),
    .busy_o   (busy),
    .done_o   (done_o),
    .sdata_o  (sdata_o),
    .dly_en_o (dly_en)
  );

  assign busy_o = busy;
endmodule

// File: rtl/sercmd_tx_chk.sv
module sercmd_tx_chk #(
  parameter int unsigned DLY_LAST = 2,
  parameter int unsigned CNT_W    = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             sclk_o,
  input logic             sdata_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [CNT_W-1:0] dly_cnt_i
);
  a_r2_start_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o);

  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dly_cnt_i <= CNT_W'(DLY_LAST));

  a_r4_launch_at_terminal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(sdata_o) |-> dly_cnt_i == CNT_W'(DLY_LAST));

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));

  a_r9_idle_sclk_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sclk_o);

  a_r9_idle_data_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sdata_o);
endmodule

bind sercmd_tx sercmd_tx_chk #(.DLY_LAST(DLY_LAST), .CNT_W(DLY_CW)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .sclk_o    (sclk_o),
  .sdata_o   (sdata_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .dly_cnt_i (dly_cnt)
);

// File: tb/test_sercmd_tx.sv
module test_sercmd_tx;
  localparam int CLK_PERIOD = 20;
  localparam int CMD_W      = 8;
  localparam int DIV_LAST   = 11;
  localparam int DLY_LAST   = 2;
  localparam int HALF       = DIV_LAST + 1;
  localparam int LAUNCH     = DLY_LAST + 2;
  localparam int NFALLS     = CMD_W + 4;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [CMD_W-1:0] cmd_i = '0;
  logic             sclk_o, sdata_o, busy_o, done_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  sercmd_tx #(.CMD_W(CMD_W), .DIV_LAST(DIV_LAST), .DLY_LAST(DLY_LAST)) i_sercmd_tx (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .cmd_i   (cmd_i),
    .sclk_o  (sclk_o),
    .sdata_o (sdata_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // bit launched after falling edge j+1 (R5, R6)
  function automatic logic exp_bit(input logic [CMD_W-1:0] c, input int j);
    if (j == 0)          return 1'b1;
    else if (j <= CMD_W) return c[CMD_W-j];
    else if (j == CMD_W+1) return ~^c;
    else                 return 1'b0;
  endfunction

  task automatic t_reset();
    rst_ni = 1'b0;
    step(2);
    check("R1 sclk", int'(sclk_o), 0);
    check("R1 sdata", int'(sdata_o), 0);
    check("R1 busy", int'(busy_o), 0);
    check("R1 done", int'(done_o), 0);
    rst_ni = 1'b1;
    step(1);
  endtask

  task automatic t_idle();
    int bad = 0;
    for (int i = 0; i < 60; i++) begin
      step(1);
      if (sclk_o || sdata_o || busy_o) bad++;
    end
    check("R9 idle lines low", bad, 0);
  endtask

  task automatic run_frame(input logic [CMD_W-1:0] c, input bit intrude);
    int t = 0;
    int last_fall = 0;
    logic prev_s;
    logic prev_d;
    @(negedge clk);
    cmd_i   = c;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R2 busy after start", int'(busy_o), 1);
    prev_s = sclk_o;
    prev_d = sdata_o;
    for (int f = 1; f <= NFALLS; f++) begin
      int guard = 0;
      forever begin
        step(1);
        t++;
        guard++;
        if (prev_s && !sclk_o) break;
        prev_s = sclk_o;
        if (guard > 4*HALF) break;
      end
      prev_s = 1'b0;
      check($sformatf("R3 fall %0d spacing", f), t - last_fall, 2*HALF);
      last_fall = t;
      step(LAUNCH - 1);
      t += LAUNCH - 1;
      check($sformatf("R4 hold before launch f%0d", f), int'(sdata_o), int'(prev_d));
      step(1);
      t++;
      if (f < NFALLS) begin
        check($sformatf("R5 bit %0d cmd=%0h", f-1, c), int'(sdata_o), int'(exp_bit(c, f-1)));
        if (f == CMD_W + 2)
          check($sformatf("R6 parity cmd=%0h", c), int'(sdata_o), int'(~^c));
        check("R7 busy during frame", int'(busy_o), 1);
        prev_d = sdata_o;
      end else begin
        check("R7 line low at end", int'(sdata_o), 0);
        check("R7 busy drops", int'(busy_o), 0);
        check("R7 done pulse", int'(done_o), 1);
        step(1);
        check("R7 done one cycle", int'(done_o), 0);
      end
      if (intrude && f == 3) begin
        cmd_i   = ~c;
        start_i = 1'b1;
        step(1);
        t++;
        start_i = 1'b0;
        check("R8 busy kept", int'(busy_o), 1);
        check("R8 no done", int'(done_o), 0);
      end
    end
  endtask

  task automatic t_mid_reset();
    @(negedge clk);
    cmd_i   = 8'hC3;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    step(3*HALF + 2);
    rst_ni = 1'b0;
    #1;
    check("R1 async sclk", int'(sclk_o), 0);
    check("R1 async sdata", int'(sdata_o), 0);
    check("R1 async busy", int'(busy_o), 0);
    step(2);
    rst_ni = 1'b1;
    step(2);
    check("R1 stays idle", int'(busy_o), 0);
  endtask

  initial begin
    t_reset();
    t_idle();
    run_frame(8'h53, 1'b0);
    run_frame(8'h00, 1'b0);
    run_frame(8'hFF, 1'b0);
    run_frame(8'h01, 1'b0);
    run_frame(8'hA6, 1'b1);
    t_mid_reset();
    run_frame(8'h53, 1'b0);
    t_idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule